// File: doc/BRIEF.md
# Reset Cause and Request Register

This block is one 32-bit control word on a simple register bus. Its upper five bits serve two purposes. Three of them are sticky cause flags. The first records that the last reset was a power-on. The other two record that a front-panel power-on button or a front-panel external-reset button was pressed. Software clears each of these flags by writing a one to it. The remaining two bits are plain read/write soft-reset request bits. Writing either of them asks the system reset sequencer for a reset. The sequencer itself and the button debouncing sit outside this block.

The block has two reset inputs. The power-good reset wipes everything, including the memory of whether a system reset has been seen. The ordinary system reset is synchronous. The first system reset after power-good loads the power-on cause flag. Any later system reset leaves the word exactly as it was, so software can read the cause after a warm restart.

Top module: `rst_cause_reg`

## Requirements
- R1: The word answers on byte addresses BASE_ADDR to BASE_ADDR+7 (default 0xF020 to 0xF027). A read outside that window returns zero, and a write outside it changes nothing.
- R2: Bits 26:0 always read as zero, whatever was written to them.
- R3: Bits 31 (power-on cause), 28 (power-on button) and 27 (external-reset button) are write-one-to-clear. Writing a zero to one of these bits leaves it unchanged.
- R4: Bits 30 (soft power-on request) and 29 (soft external reset request) take the written value on every write.
- R5: A write with bit 30 or bit 29 set makes rst_req high for exactly one cycle, in the cycle after the write. A write with both bits clear gives no pulse.
- R6: With each pulse, rst_cause_por reports 1 when bit 30 was written as one, even if bit 29 was also set. It reports 0 when only bit 29 was set.
- R7: A rising edge on btn_por sets bit 28, and a rising edge on btn_xir sets bit 27. A held level does not set the bit again. When an edge and a clearing write land in the same cycle, the bit ends up set.
- R8: The first system reset after power-good loads the word with 0x8000_0000. Every later system reset leaves the word unchanged.
- R9: While power-good reset is asserted, the word is zero and rst_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Asynchronous power-good reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not addressed |
| btn_por | input | 1 | Synchronous power-on button level |
| btn_xir | input | 1 | Synchronous external-reset button level |
| rst_req | output | 1 | One-cycle system reset request |
| rst_cause_por | output | 1 | Kind of the last request: 1 power-on, 0 external |

## Verification
The bench uses the default 16-bit address and base 0xF020. This lets it reach both edges of the eight-byte window, plus the addresses just below and just above it. It applies power-good reset twice and system reset three times. That covers the first-reset load and the preserving later reset, and it shows that the power-good reset re-arms the load. Button edges are timed to coincide with clearing writes, which exercises the set-over-clear case.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int SPAN = 8
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              sys_rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              btn_por,
  input  logic              btn_xir,
  output logic              rst_req,
  output logic              rst_cause_por
);

  localparam logic [31:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [31:0] LOAD_MASK = 32'h6000_0000;
  localparam logic [31:0] POR_VALUE = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(SPAN - 1);

  logic [31:0] ctl_q, ctl_d;
  logic        first_done_q;
  logic        bpor_q, bxir_q;

  wire hit      = (addr >= BASE_ADDR) && (addr <= LAST_ADDR);
  wire wr_hit   = sel & wr & hit;
  wire soft_req = wr_hit & |(wdata & LOAD_MASK);
  wire bpor_rise = btn_por & ~bpor_q;
  wire bxir_rise = btn_xir & ~bxir_q;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_hit) begin
      ctl_d = ctl_q & ~(wdata & W1C_MASK);
      ctl_d = (ctl_d & ~LOAD_MASK) | (wdata & LOAD_MASK);
    end
    if (bpor_rise) ctl_d[28] = 1'b1;
    if (bxir_rise) ctl_d[27] = 1'b1;
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      ctl_q         <= '0;
      first_done_q  <= 1'b0;
      bpor_q        <= 1'b0;
      bxir_q        <= 1'b0;
      rst_req       <= 1'b0;
      rst_cause_por <= 1'b0;
    end else begin
      bpor_q <= btn_por;
      bxir_q <= btn_xir;
      if (!sys_rst_n) begin
        rst_req <= 1'b0;
        if (!first_done_q) begin
          ctl_q        <= POR_VALUE;
          first_done_q <= 1'b1;
        end
      end else begin
        ctl_q   <= ctl_d;
        rst_req <= soft_req;
        if (soft_req) rst_cause_por <= wdata[30];
      end
    end
  end

  assign rdata = (sel && hit) ? ctl_q : '0;

endmodule

module rst_cause_reg_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
  input logic              clk,
  input logic              pwr_rst_n,
  input logic              sys_rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              btn_por,
  input logic              rst_req,
  input logic              rst_cause_por,
  input logic [31:0]       ctl_q,
  input logic              first_done_q
);

  wire base_wr = sys_rst_n && sel && wr && (addr == BASE_ADDR);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rdata[26:0] == 27'd0); // R2
  AST_W1C_POR: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    base_wr && wdata[31] |=> !ctl_q[31]); // R3
  AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    base_wr |=> ctl_q[30:29] == $past(wdata[30:29])); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_req |=> !rst_req); // R5
  AST_CAUSE_PRIO: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    base_wr && wdata[30] |=> rst_req && rst_cause_por); // R6
  AST_BTN_SET: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    sys_rst_n && $rose(btn_por) |=> ctl_q[28]); // R7
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !sys_rst_n && !first_done_q |=> ctl_q == 32'h8000_0000); // R8
  AST_LATER_KEEP: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !sys_rst_n && first_done_q |=> $stable(ctl_q)); // R8
  AST_PWR_CLEAR: assert property (@(posedge clk)
    !pwr_rst_n |-> ctl_q == 32'd0 && !rst_req); // R9

endmodule

bind rst_cause_reg rst_cause_reg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_n(sys_rst_n), .sel(sel), .wr(wr),
  .addr(addr), .wdata(wdata), .rdata(rdata), .btn_por(btn_por),
  .rst_req(rst_req), .rst_cause_por(rst_cause_por), .ctl_q(ctl_q),
  .first_done_q(first_done_q)
);

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {write addr, write data, expected word, expected req, expected cause}
  localparam logic [81:0] VEC [NVEC] = '{
    {16'hF020, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0},
    {16'hF020, 32'h2000_0000, 32'hA000_0000, 1'b1, 1'b0},
    {16'hF024, 32'h6000_0000, 32'hE000_0000, 1'b1, 1'b1},
    {16'hF020, 32'h4000_0000, 32'hC000_0000, 1'b1, 1'b1},
    {16'hF000, 32'hFFFF_FFFF, 32'hC000_0000, 1'b0, 1'b0},
    {16'hF028, 32'h8000_0000, 32'hC000_0000, 1'b0, 1'b0},
    {16'hF027, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {16'hF020, 32'h07FF_FFFF, 32'h0000_0000, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic pwr_rst_n, sys_rst_n, sel, wr, btn_por, btn_xir;
  logic [15:0] addr;
  logic [31:0] wdata, rdata;
  logic rst_req, rst_cause_por;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_n(sys_rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .btn_por(btn_por), .btn_xir(btn_xir),
    .rst_req(rst_req), .rst_cause_por(rst_cause_por)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 v = rdata;
    sel = 1'b0;
  endtask

  task automatic wrw(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    pwr_rst_n = 0; sys_rst_n = 0; sel = 0; wr = 0; addr = '0; wdata = '0;
    btn_por = 0; btn_xir = 0;
    repeat (3) @(negedge clk);
    rd(16'hF020, v); chk("R9 word in power reset", v, 32'h0);
    chk("R9 req in power reset", {31'd0, rst_req}, 32'd0);
    @(negedge clk); pwr_rst_n = 1;
    @(negedge clk); sys_rst_n = 1;
    rd(16'hF020, v); chk("R8 first reset load", v, 32'h8000_0000);

    for (int i = 0; i < NVEC; i++) begin
      wrw(VEC[i][81:66], VEC[i][65:34]);
      chk($sformatf("R5 req vec%0d", i), {31'd0, rst_req}, {31'd0, VEC[i][1]});
      if (VEC[i][1])
        chk($sformatf("R6 cause vec%0d", i), {31'd0, rst_cause_por}, {31'd0, VEC[i][0]});
      @(negedge clk);
      chk($sformatf("R5 single pulse vec%0d", i), {31'd0, rst_req}, 32'd0);
      rd(16'hF024, v);
      chk($sformatf("R1 R2 R3 R4 word vec%0d", i), v, VEC[i][33:2]);
    end

    rd(16'hF01F, v); chk("R1 below window", v, 32'h0);
    rd(16'hF028, v); chk("R1 above window", v, 32'h0);

    @(negedge clk); btn_por = 1;
    rd(16'hF020, v); chk("R7 por button edge", v, 32'h1000_0000);
    @(negedge clk); btn_xir = 1;
    rd(16'hF020, v); chk("R7 xir button edge", v, 32'h1800_0000);
    wrw(16'hF020, 32'h1000_0000);
    rd(16'hF020, v); chk("R3 R7 clear one, held level no reset", v, 32'h0800_0000);
    wrw(16'hF020, 32'h0800_0000);
    rd(16'hF020, v); chk("R3 clear xir", v, 32'h0);
    @(negedge clk); btn_xir = 0;
    @(negedge clk);
    btn_xir = 1; sel = 1; wr = 1; addr = 16'hF020; wdata = 32'h0800_0000;
    @(negedge clk); sel = 0; wr = 0;
    rd(16'hF020, v); chk("R7 set wins over clear", v, 32'h0800_0000);

    wrw(16'hF020, 32'h6000_0000);
    chk("R6 both soft bits", {30'd0, rst_req, rst_cause_por}, 32'd3);
    @(negedge clk); sys_rst_n = 0;
    repeat (2) @(negedge clk); sys_rst_n = 1;
    rd(16'hF020, v); chk("R8 later reset keeps word", v, 32'h6800_0000);
    chk("R5 no req after reset", {31'd0, rst_req}, 32'd0);
    rd(16'hF027, v); chk("R1 top of window", v, 32'h6800_0000);

    @(negedge clk); pwr_rst_n = 0; sys_rst_n = 0;
    rd(16'hF020, v); chk("R9 power reset clears", v, 32'h0);
    @(negedge clk); pwr_rst_n = 1;
    @(negedge clk); sys_rst_n = 1;
    rd(16'hF020, v); chk("R8 load re-armed", v, 32'h8000_0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule